// File: doc/BRIEF.md
# Transmit Descriptor Ring Tracker

This block keeps the bookkeeping for a circular ring of transmit buffer descriptors that a host producer and a DMA engine share. The host offers one buffer at a time (address, length and packet-start/packet-end marks). The block stores the buffer in the slot at its send index and sets that slot's ownership bit, which hands the slot to the DMA. It then advances the send index and pulses a kick line for DMA engines that must be told to look again. A packet split across several buffers simply occupies several consecutive slots.

The DMA engine reads slots through an indexed read port. When it has sent a slot, it writes back a status word, for example a timestamp, and this clears the slot's ownership bit. It then raises a completion event. The event starts a reclaim walk. The walk looks only at the slot under the reclaim index. If that slot is no longer owned, the walk presents its address, status and end-of-packet mark, advances the index and tries the next slot on the following cycle. It stops at the first slot still owned by the DMA. A counter of host-owned slots tells a full ring from an empty one when the two indexes are equal. Each reclaim is followed by a one-cycle pulse that wakes any waiting producer.

Top module: `txr_ring_top`

## Requirements
- R1: After reset (asynchronous assertion, release taking effect two clock edges after rst_n rises), enq_slot and rcl_slot are 0, free_cnt equals DEPTH, no slot reads as owned on the DMA read port, and rcl_valid is low.
- R2: An accepted enqueue (enq_valid and enq_ready high at a clock edge) stores the address, length, start and end marks into slot enq_slot and sets its ownership bit; from the next cycle the DMA read port shows these values for that slot. enq_slot advances by one and wraps from DEPTH-1 to 0.
- R3: enq_ready is low whenever free_cnt is 0. An enq_valid offered then changes neither enq_slot nor free_cnt, and does not pulse dma_kick.
- R4: dma_kick is high for exactly the one cycle after each accepted enqueue.
- R5: A write-back (dma_wb_valid) to a slot that is owned clears its ownership bit and records dma_wb_stat. A write-back to a slot whose ownership bit is already clear is ignored and leaves both the bit and the recorded status unchanged.
- R6: After a cmpl_evt pulse, the block reclaims slots starting at rcl_slot, one per cycle. In each such cycle rcl_valid is high and rcl_slot, rcl_addr, rcl_stat and rcl_eop describe the slot. rcl_slot then advances by one, wrapping at DEPTH.
- R7: Reclaim stops at the first slot that is still owned, even if later slots have been written back. Those later slots are reclaimed, in ring order, only after the earlier slot completes and a new event arrives.
- R8: free_cnt falls by one for each accepted enqueue and rises by one for each reclaim. It is unchanged when both happen in the same cycle, and it stays between 0 and DEPTH.
- R9: slot_free is high for the one cycle after each reclaim.
- R10: With the two indexes equal, the ring is full when free_cnt is 0: an event then reclaims all DEPTH completed slots. The ring is empty when free_cnt is DEPTH: an event then reclaims nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Host offers a buffer |
| enq_ready | output | 1 | A free slot exists and the buffer can be taken |
| enq_addr | input | AW | Buffer address |
| enq_len | input | LW | Buffer length in bytes |
| enq_sop | input | 1 | Buffer starts a packet |
| enq_eop | input | 1 | Buffer ends a packet |
| enq_slot | output | IW | Send index: the slot the next buffer goes to |
| dma_rd_idx | input | IW | Slot the DMA engine reads |
| dma_rd_own | output | 1 | Ownership bit of the read slot |
| dma_rd_addr | output | AW | Address in the read slot |
| dma_rd_len | output | LW | Length in the read slot |
| dma_rd_sop | output | 1 | Packet-start mark of the read slot |
| dma_rd_eop | output | 1 | Packet-end mark of the read slot |
| dma_kick | output | 1 | One-cycle poll request after a hand-off |
| dma_wb_valid | input | 1 | DMA writes back a finished slot |
| dma_wb_idx | input | IW | Slot being written back |
| dma_wb_stat | input | SW | Status word for the finished slot |
| cmpl_evt | input | 1 | Completion event from the DMA engine |
| rcl_valid | output | 1 | A slot is reclaimed this cycle |
| rcl_slot | output | IW | Reclaim index |
| rcl_addr | output | AW | Buffer address of the slot at the reclaim index |
| rcl_stat | output | SW | Status recorded for that slot |
| rcl_eop | output | 1 | That slot ends a packet |
| slot_free | output | 1 | Wake-up pulse for a waiting producer |
| free_cnt | output | CW | Number of slots owned by the host |

## Verification
The hardest state to reach from the ports is an out-of-order completion: a slot past the reclaim index has already been written back while the slot at the index is still owned. The bench builds it deliberately. It enqueues three buffers across the wrap point and writes back the second and third first. It then raises an event and expects no reclaim at all. After that it completes the first buffer and expects all three reclaimed in ring order. The full ring with equal indexes is built by enqueuing DEPTH buffers without completing any, and a reclaim coinciding with an enqueue is built by timing the enqueue into the first reclaim cycle.

// File: rtl/txr_pkg.sv
package txr_pkg;
  // Per-slot control flags kept beside the buffer fields.
  typedef struct packed {
    logic own;   // slot handed to the DMA engine
    logic sop;   // buffer starts a packet
    logic eop;   // buffer ends a packet
  } txr_flags_t;
endpackage

// File: rtl/txr_idx_ctr.sv
module txr_idx_ctr #(
  parameter  int DEPTH = 8,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] idx_n;

  always_comb begin
    idx_n = idx;
    if (adv) begin
      idx_n = (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_n;
  end
endmodule

// File: rtl/txr_desc_store.sv
module txr_desc_store
  import txr_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int AW    = 32,
  parameter  int LW    = 16,
  parameter  int SW    = 32,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  // host write port
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [LW-1:0] wr_len,
  input  logic          wr_sop,
  input  logic          wr_eop,
  // DMA write-back port
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  logic [SW-1:0] wb_stat,
  // DMA read port
  input  logic [IW-1:0] da_idx,
  output logic          da_own,
  output logic [AW-1:0] da_addr,
  output logic [LW-1:0] da_len,
  output logic          da_sop,
  output logic          da_eop,
  // reclaim read port
  input  logic [IW-1:0] rc_idx,
  output logic          rc_own,
  output logic [AW-1:0] rc_addr,
  output logic [SW-1:0] rc_stat,
  output logic          rc_eop
);
  txr_flags_t    flg_q  [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [LW-1:0] len_q  [DEPTH];
  logic [SW-1:0] stat_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    txr_flags_t    flg_r, flg_n;
    logic [AW-1:0] addr_r;
    logic [LW-1:0] len_r;
    logic [SW-1:0] stat_r;
    logic          wr_hit, wb_hit;

    assign wr_hit = wr_en && (wr_idx == IW'(g));
    // a write-back only lands on a slot the DMA actually owns
    assign wb_hit = wb_en && (wb_idx == IW'(g)) && flg_r.own;

    always_comb begin
      flg_n = flg_r;
      if (wr_hit) begin
        flg_n.own = 1'b1;
        flg_n.sop = wr_sop;
        flg_n.eop = wr_eop;
      end else if (wb_hit) begin
        flg_n.own = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flg_r <= '0;
      else        flg_r <= flg_n;
    end

    // datapath registers: enable only, no reset
    always_ff @(posedge clk) begin
      if (wr_hit) begin
        addr_r <= wr_addr;
        len_r  <= wr_len;
      end
    end

    always_ff @(posedge clk) begin
      if (wb_hit) stat_r <= wb_stat;
    end

    assign flg_q[g]  = flg_r;
    assign addr_q[g] = addr_r;
    assign len_q[g]  = len_r;
    assign stat_q[g] = stat_r;
  end

  assign da_own  = flg_q[da_idx].own;
  assign da_sop  = flg_q[da_idx].sop;
  assign da_eop  = flg_q[da_idx].eop;
  assign da_addr = addr_q[da_idx];
  assign da_len  = len_q[da_idx];

  assign rc_own  = flg_q[rc_idx].own;
  assign rc_eop  = flg_q[rc_idx].eop;
  assign rc_addr = addr_q[rc_idx];
  assign rc_stat = stat_q[rc_idx];
endmodule

// File: rtl/txr_reclaim_ctl.sv
module txr_reclaim_ctl #(
  parameter  int DEPTH = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          enq_fire,
  input  logic          head_own,
  output logic          rcl_fire,
  output logic [CW-1:0] free_cnt,
  output logic          slot_free
);
  logic          pend_q, pend_n;
  logic [CW-1:0] cnt_n;
  logic          sf_n;
  logic          can_take;

  // head slot finished and the ring holds at least one DMA slot
  assign can_take = !head_own && (free_cnt != CW'(DEPTH));
  assign rcl_fire = pend_q && can_take;

  always_comb begin
    pend_n = evt || rcl_fire;
    sf_n   = rcl_fire;
    cnt_n  = free_cnt;
    unique case ({enq_fire, rcl_fire})
      2'b10:   cnt_n = free_cnt - 1'b1;
      2'b01:   cnt_n = free_cnt + 1'b1;
      default: cnt_n = free_cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      free_cnt  <= CW'(DEPTH);
      slot_free <= 1'b0;
    end else begin
      pend_q    <= pend_n;
      free_cnt  <= cnt_n;
      slot_free <= sf_n;
    end
  end
endmodule

// File: rtl/txr_ring_top.sv
module txr_ring_top #(
  parameter  int DEPTH = 8,
  parameter  int AW    = 32,
  parameter  int LW    = 16,
  parameter  int SW    = 32,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic [AW-1:0] enq_addr,
  input  logic [LW-1:0] enq_len,
  input  logic          enq_sop,
  input  logic          enq_eop,
  output logic [IW-1:0] enq_slot,
  input  logic [IW-1:0] dma_rd_idx,
  output logic          dma_rd_own,
  output logic [AW-1:0] dma_rd_addr,
  output logic [LW-1:0] dma_rd_len,
  output logic          dma_rd_sop,
  output logic          dma_rd_eop,
  output logic          dma_kick,
  input  logic          dma_wb_valid,
  input  logic [IW-1:0] dma_wb_idx,
  input  logic [SW-1:0] dma_wb_stat,
  input  logic          cmpl_evt,
  output logic          rcl_valid,
  output logic [IW-1:0] rcl_slot,
  output logic [AW-1:0] rcl_addr,
  output logic [SW-1:0] rcl_stat,
  output logic          rcl_eop,
  output logic          slot_free,
  output logic [CW-1:0] free_cnt
);
  logic [1:0] rs_q;
  logic       rst_s;
  logic       enq_fire;
  logic       head_own;
  logic       kick_n;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  assign enq_ready = rst_s && (free_cnt != '0);
  assign enq_fire  = enq_valid && enq_ready;
  assign kick_n    = enq_fire;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) dma_kick <= 1'b0;
    else        dma_kick <= kick_n;
  end

  txr_idx_ctr #(.DEPTH(DEPTH)) u_send_idx (
    .clk(clk), .rst_n(rst_s), .adv(enq_fire), .idx(enq_slot)
  );

  txr_idx_ctr #(.DEPTH(DEPTH)) u_rcl_idx (
    .clk(clk), .rst_n(rst_s), .adv(rcl_valid), .idx(rcl_slot)
  );

  txr_desc_store #(.DEPTH(DEPTH), .AW(AW), .LW(LW), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_s),
    .wr_en(enq_fire), .wr_idx(enq_slot), .wr_addr(enq_addr),
    .wr_len(enq_len), .wr_sop(enq_sop), .wr_eop(enq_eop),
    .wb_en(dma_wb_valid), .wb_idx(dma_wb_idx), .wb_stat(dma_wb_stat),
    .da_idx(dma_rd_idx), .da_own(dma_rd_own), .da_addr(dma_rd_addr),
    .da_len(dma_rd_len), .da_sop(dma_rd_sop), .da_eop(dma_rd_eop),
    .rc_idx(rcl_slot), .rc_own(head_own), .rc_addr(rcl_addr),
    .rc_stat(rcl_stat), .rc_eop(rcl_eop)
  );

  txr_reclaim_ctl #(.DEPTH(DEPTH)) u_rcl_ctl (
    .clk(clk), .rst_n(rst_s), .evt(cmpl_evt), .enq_fire(enq_fire),
    .head_own(head_own), .rcl_fire(rcl_valid), .free_cnt(free_cnt),
    .slot_free(slot_free)
  );
endmodule

// File: rtl/txr_ring_sva.sv
module txr_ring_sva #(
  parameter  int DEPTH = 8,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enq_valid,
  input logic          enq_ready,
  input logic [IW-1:0] enq_slot,
  input logic          dma_kick,
  input logic          rcl_valid,
  input logic [IW-1:0] rcl_slot,
  input logic          slot_free,
  input logic [CW-1:0] free_cnt
);
  logic acc;
  assign acc = enq_valid && enq_ready;

  a_r3_no_enq_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == '0) |-> !enq_ready);

  a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(DEPTH));

  a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (free_cnt == $past(free_cnt) - CW'($past(acc)) + CW'($past(rcl_valid))));

  a_r4_kick_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> dma_kick);

  a_r4_kick_only_after_enq: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !dma_kick);

  a_r9_free_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rcl_valid |=> slot_free);

  a_r2_send_advance: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (enq_slot == (($past(enq_slot) == IW'(DEPTH - 1)) ? '0 : $past(enq_slot) + 1'b1)));

  a_r6_rcl_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rcl_valid |=> (rcl_slot == (($past(rcl_slot) == IW'(DEPTH - 1)) ? '0 : $past(rcl_slot) + 1'b1)));

  a_r10_empty_no_rcl: assert property (@(posedge clk) disable iff (!rst_n)
    (free_cnt == CW'(DEPTH)) |-> !rcl_valid);
endmodule

bind txr_ring_top txr_ring_sva #(.DEPTH(DEPTH)) u_sva (
  .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .enq_slot(enq_slot), .dma_kick(dma_kick), .rcl_valid(rcl_valid),
  .rcl_slot(rcl_slot), .slot_free(slot_free), .free_cnt(free_cnt)
);

// File: tb/txr_ring_top_tb_top.sv
module txr_ring_top_tb_top;
  localparam int DEPTH = 8;
  localparam int IW = 3;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_ready, enq_sop = 1'b0, enq_eop = 1'b0;
  logic [31:0] enq_addr = '0;
  logic [15:0] enq_len = '0;
  logic [IW-1:0] enq_slot, dma_rd_idx = '0, dma_wb_idx = '0, rcl_slot;
  logic dma_rd_own, dma_rd_sop, dma_rd_eop, dma_kick;
  logic [31:0] dma_rd_addr, rcl_addr, rcl_stat, dma_wb_stat = '0;
  logic [15:0] dma_rd_len;
  logic dma_wb_valid = 1'b0, cmpl_evt = 1'b0, rcl_valid, rcl_eop, slot_free;
  logic [CW-1:0] free_cnt;

  always #4 clk = ~clk;

  txr_ring_top dut_i (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
    .enq_addr(enq_addr), .enq_len(enq_len), .enq_sop(enq_sop), .enq_eop(enq_eop),
    .enq_slot(enq_slot), .dma_rd_idx(dma_rd_idx), .dma_rd_own(dma_rd_own),
    .dma_rd_addr(dma_rd_addr), .dma_rd_len(dma_rd_len), .dma_rd_sop(dma_rd_sop),
    .dma_rd_eop(dma_rd_eop), .dma_kick(dma_kick), .dma_wb_valid(dma_wb_valid),
    .dma_wb_idx(dma_wb_idx), .dma_wb_stat(dma_wb_stat), .cmpl_evt(cmpl_evt),
    .rcl_valid(rcl_valid), .rcl_slot(rcl_slot), .rcl_addr(rcl_addr),
    .rcl_stat(rcl_stat), .rcl_eop(rcl_eop), .slot_free(slot_free), .free_cnt(free_cnt)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] len;
    logic        sop;
    logic        eop;
    logic [31:0] stat;
  } row_t;

  // three packets: one buffer, two buffers, three buffers
  localparam row_t VEC [6] = '{
    '{32'h0000_1000, 16'd64,   1'b1, 1'b1, 32'h0000_00A0},
    '{32'h0000_2000, 16'd592,  1'b1, 1'b0, 32'h0000_00B1},
    '{32'h0000_2250, 16'd100,  1'b0, 1'b1, 32'h0000_00B2},
    '{32'h0000_3000, 16'd592,  1'b1, 1'b0, 32'h0000_00C1},
    '{32'h0000_3250, 16'd592,  1'b0, 1'b0, 32'h0000_00C2},
    '{32'h0000_34A0, 16'd316,  1'b0, 1'b1, 32'h0000_00C3}
  };

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int nlog;
  logic [IW-1:0] lg_slot [16];
  logic [31:0]   lg_addr [16];
  logic [31:0]   lg_stat [16];
  logic          lg_eop  [16];
  bit            sf_ok;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic enq(input logic [31:0] a, input logic [15:0] l, input logic s, input logic e);
    @(negedge clk);
    enq_valid = 1'b1; enq_addr = a; enq_len = l; enq_sop = s; enq_eop = e;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic wb(input int idx, input logic [31:0] st);
    @(negedge clk);
    dma_wb_valid = 1'b1; dma_wb_idx = IW'(idx); dma_wb_stat = st;
    @(negedge clk);
    dma_wb_valid = 1'b0;
  endtask

  // pulse the event, then log every reclaim cycle
  task automatic evt_collect();
    bit prev;
    @(negedge clk);
    cmpl_evt = 1'b1;
    @(negedge clk);
    cmpl_evt = 1'b0;
    nlog = 0; prev = 1'b0; sf_ok = 1'b1;
    for (int k = 0; k < DEPTH + 3; k++) begin
      if (prev && !slot_free) sf_ok = 1'b0;
      prev = rcl_valid;
      if (rcl_valid) begin
        lg_slot[nlog] = rcl_slot; lg_addr[nlog] = rcl_addr;
        lg_stat[nlog] = rcl_stat; lg_eop[nlog] = rcl_eop;
        nlog++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int sh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(enq_slot == 0, "R1", "enq_slot", enq_slot, 0);
    chk(rcl_slot == 0, "R1", "rcl_slot", rcl_slot, 0);
    chk(free_cnt == CW'(DEPTH), "R1", "free_cnt", free_cnt, DEPTH);
    chk(enq_ready && !rcl_valid, "R1", "ready/valid", {enq_ready, rcl_valid}, 2'b10);
    begin
      bit any_own = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        dma_rd_idx = IW'(i); #1;
        if (dma_rd_own) any_own = 1'b1;
      end
      chk(!any_own, "R1", "owned slot after reset", any_own, 0);
    end

    // table walk: R2 enqueue and R4 kick
    for (int i = 0; i < 6; i++) begin
      chk(enq_slot == IW'(i), "R2", "send index", enq_slot, i);
      enq(VEC[i].addr, VEC[i].len, VEC[i].sop, VEC[i].eop);
      chk(dma_kick, "R4", "kick after enqueue", dma_kick, 1);
      dma_rd_idx = IW'(i); #1;
      chk(dma_rd_own && dma_rd_addr == VEC[i].addr && dma_rd_len == VEC[i].len &&
          dma_rd_sop == VEC[i].sop && dma_rd_eop == VEC[i].eop,
          "R2", "slot contents", dma_rd_addr, VEC[i].addr);
    end
    @(negedge clk);
    chk(!dma_kick, "R4", "kick one cycle", dma_kick, 0);
    chk(free_cnt == 2, "R8", "count after 6 enqueues", free_cnt, 2);
    for (int i = 0; i < 6; i++) wb(i, VEC[i].stat);
    dma_rd_idx = 3'd4; #1;
    chk(!dma_rd_own, "R5", "own cleared by write-back", dma_rd_own, 0);
    evt_collect();
    chk(nlog == 6, "R6", "reclaim count", nlog, 6);
    for (int i = 0; i < 6; i++) begin
      chk(lg_slot[i] == IW'(i) && lg_addr[i] == VEC[i].addr && lg_stat[i] == VEC[i].stat &&
          lg_eop[i] == VEC[i].eop, "R6", "reclaim record", lg_stat[i], VEC[i].stat);
    end
    chk(sf_ok, "R9", "slot_free after each reclaim", sf_ok, 1);
    chk(free_cnt == CW'(DEPTH), "R8", "count after drain", free_cnt, DEPTH);

    // R7 out-of-order completion across the wrap
    enq(32'h5000, 16'd10, 1'b1, 1'b0);
    enq(32'h5100, 16'd10, 1'b0, 1'b0);
    enq(32'h5200, 16'd10, 1'b0, 1'b1);
    chk(enq_slot == 1, "R2", "send index wraps", enq_slot, 1);
    wb(7, 32'h77); wb(0, 32'h70);
    evt_collect();
    chk(nlog == 0, "R7", "no reclaim past owned head", nlog, 0);
    chk(free_cnt == 5 && rcl_slot == 6, "R7", "count held", free_cnt, 5);
    wb(6, 32'h66);
    evt_collect();
    chk(nlog == 3, "R7", "reclaims after head completes", nlog, 3);
    chk(lg_slot[0] == 6 && lg_slot[1] == 7 && lg_slot[2] == 0, "R7", "ring order",
        {lg_slot[0], lg_slot[1], lg_slot[2]}, {3'd6, 3'd7, 3'd0});
    chk(lg_stat[0] == 32'h66 && lg_stat[1] == 32'h77 && lg_stat[2] == 32'h70, "R7",
        "status order", lg_stat[2], 32'h70);

    // R5 ignored write-backs
    enq(32'h6000, 16'd20, 1'b1, 1'b1);
    wb(1, 32'h11);
    wb(1, 32'h22);
    wb(3, 32'h33);
    dma_rd_idx = 3'd3; #1;
    chk(!dma_rd_own, "R5", "write-back to free slot leaves own clear", dma_rd_own, 0);
    evt_collect();
    chk(nlog == 1 && lg_stat[0] == 32'h11, "R5", "second write-back ignored", lg_stat[0], 32'h11);

    // R3 / R10 full ring with equal indexes
    sh = 2;
    for (int i = 0; i < DEPTH; i++) enq(32'h7000 + 32'(i), 16'd8, 1'b1, 1'b1);
    chk(free_cnt == 0 && !enq_ready, "R3", "full ring not ready", {free_cnt, enq_ready}, 0);
    chk(enq_slot == rcl_slot, "R10", "indexes equal when full", enq_slot, rcl_slot);
    enq(32'hDEAD, 16'd1, 1'b1, 1'b1);
    chk(enq_slot == IW'(sh) && free_cnt == 0, "R3", "refused enqueue", enq_slot, sh);
    chk(!dma_kick, "R3", "no kick on refused enqueue", dma_kick, 0);
    for (int i = 0; i < DEPTH; i++) wb((sh + i) % DEPTH, 32'h100 + 32'(i));
    evt_collect();
    chk(nlog == DEPTH, "R10", "full ring drains", nlog, DEPTH);
    chk(lg_addr[0] == 32'h7000 && lg_addr[DEPTH-1] == 32'h7007, "R10", "full drain order",
        lg_addr[DEPTH-1], 32'h7007);

    // R10 empty ring event
    evt_collect();
    chk(nlog == 0 && free_cnt == CW'(DEPTH), "R10", "event on empty ring", nlog, 0);

    // R8 enqueue and reclaim in the same cycle
    enq(32'h8000, 16'd4, 1'b1, 1'b1);
    wb(2, 32'h88);
    @(negedge clk); cmpl_evt = 1'b1;
    @(negedge clk); cmpl_evt = 1'b0;
    chk(rcl_valid && free_cnt == 7, "R8", "reclaim pending", {rcl_valid, free_cnt}, 5'h17);
    enq_valid = 1'b1; enq_addr = 32'h8100; enq_sop = 1'b1; enq_eop = 1'b1;
    @(negedge clk); enq_valid = 1'b0;
    chk(free_cnt == 7, "R8", "simultaneous enqueue and reclaim", free_cnt, 7);
    chk(slot_free, "R9", "wake pulse", slot_free, 1);
    chk(enq_slot == 4 && rcl_slot == 3, "R6", "indexes after overlap",
        {enq_slot, rcl_slot}, {3'd4, 3'd3});

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule